// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects sixteen interrupt request lines from peripherals and hands one of them at a time to a processor core. Each line is configured on its own as edge-sensitive or level-sensitive and as active-high or active-low. Edge-sensitive lines are remembered in a pending register until the core takes them, while level-sensitive lines request for exactly as long as their input is held active. A fixed order (lowest line index wins) picks among the pending lines. A programmable threshold holds back lines of lower priority, and a per-line mask silences a line completely.

When a line is chosen, the block raises its interrupt output and drives an 8-bit vector number. Lines 0 to 7 give vectors 32 to 39 and lines 8 to 15 give vectors 40 to 47. The output and vector stay put until the core pulses acknowledge. Configuration is written through a plain write strobe, a 2-bit register select and a 16-bit data word.

Top module: `irqc_top`

## Requirements
- R1: After reset, irq_o is 0 and vec_o is 0, every line is masked, in edge mode and active-high, and the threshold is 16 (every line passes).
- R2: When several eligible lines are pending, the lowest index is presented, and line 0 wins over all others.
- R3: In edge mode, an inactive-to-active transition of an unmasked line sets its pending bit. Further edges before that line is acknowledged merge into the same single request, and acknowledge clears the bit.
- R4: In level mode, a line requests while its input is active and is presented again after acknowledge if it is still active. Once its input is inactive, it is not presented again.
- R5: Line i is presented with vector 32+i for i in 0..7 and 40+(i-8) for i in 8..15.
- R6: A line with index i is presented only while i is below the threshold. A blocked edge request stays pending and is presented once the threshold is raised above i.
- R7: A polarity bit of 1 makes its line active-low, for both edge capture and level requests.
- R8: A masked line is never presented, and an edge on it while masked is not captured. Unmasking it later therefore presents nothing.
- R9: Once raised, irq_o stays 1 with vec_o unchanged until ack_i is high at a clock edge. irq_o is 0 in the cycle after that edge, and ack_i while irq_o is 0 has no effect.
- R10: Writes take effect on the clock edge where cfg_we is 1. cfg_sel 0 selects the mask (bit i = 1 masks line i), 1 the mode (1 = level), 2 the polarity (1 = active-low) and 3 the threshold (cfg_wdata[4:0]).
- R11: A request present at the inputs before clock edge k raises irq_o at edge k+1 when the presenter is idle, and a new request is presented at the second edge after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 16 | Interrupt request lines, bit i is line i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| ack_i | input | 1 | Acknowledge from the core |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 8 | Vector number of the presented line |

## Verification
The bench sweeps every line in both trigger modes, all 120 line pairs for priority, and every threshold against every lowest-active line. A wrong priority chain would present the higher index of a pair, and an off-by-one threshold compare would pass or block the line that sits exactly at the threshold. A second edge arriving before acknowledge is aimed at merge errors, which would show up as a second presentation. A level line still held at acknowledge must come back, while a stale level request would reappear after its input fell. Masked edges, edges on active-low lines and an acknowledge given while idle are checked at the outputs, where a capture-while-masked bug or a polarity inversion shows up as a spurious or missing interrupt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_MODE = 2'd1,
        SEL_POL  = 2'd2,
        SEL_THR  = 2'd3
    } cfg_sel_e;

    // Maps a line index to its vector: low group from lo_base, rest from hi_base.
    function automatic int unsigned line_vector(input int unsigned line,
                                                input int unsigned group,
                                                input int unsigned lo_base,
                                                input int unsigned hi_base);
        if (line < group) return lo_base + line;
        return hi_base + (line - group);
    endfunction

endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int unsigned N_LINES = 16,
    parameter int unsigned THR_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         sel,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] mask_q,
    output logic [N_LINES-1:0] mode_q,
    output logic [N_LINES-1:0] pol_q,
    output logic [THR_W-1:0]   thr_q
);

    typedef struct packed {
        logic [N_LINES-1:0] mask;
        logic [N_LINES-1:0] mode;
        logic [N_LINES-1:0] pol;
        logic [THR_W-1:0]   thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (cfg_sel_e'(sel))
                SEL_MASK: cfg_d.mask = wdata;
                SEL_MODE: cfg_d.mode = wdata;
                SEL_POL:  cfg_d.pol  = wdata;
                SEL_THR:  cfg_d.thr  = wdata[THR_W-1:0];
                default:  cfg_d      = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask <= '1;
            cfg_q.mode <= '0;
            cfg_q.pol  <= '0;
            cfg_q.thr  <= THR_W'(N_LINES);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_q = cfg_q.mask;
    assign mode_q = cfg_q.mode;
    assign pol_q  = cfg_q.pol;
    assign thr_q  = cfg_q.thr;

endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int unsigned N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic [N_LINES-1:0] mask,
    input  logic [N_LINES-1:0] mode,
    input  logic [N_LINES-1:0] pol,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] pend_o
);

    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] pend;
    } cap_t;

    cap_t st_d, st_q;
    logic [N_LINES-1:0] act;
    logic [N_LINES-1:0] edge_set;

    always_comb begin
        act      = line_in ^ pol;
        edge_set = act & ~st_q.prev & ~mask;
        st_d     = st_q;
        st_d.prev = act;
        for (int i = 0; i < int'(N_LINES); i++) begin
            if (mode[i]) begin
                st_d.pend[i] = act[i];
            end else begin
                // a fresh edge in the clearing cycle is kept
                st_d.pend[i] = (st_q.pend[i] & ~clr[i]) | edge_set[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int unsigned N_LINES = 16,
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned THR_W   = 5
) (
    input  logic [N_LINES-1:0] req,
    input  logic [THR_W-1:0]   thr,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);

    logic [N_LINES-1:0] elig;
    logic [N_LINES-1:0] win;
    logic [N_LINES:0]   seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < int'(N_LINES); g++) begin : g_chain
        assign elig[g]   = req[g] & (thr > THR_W'(g));
        assign win[g]    = elig[g] & ~seen[g];
        assign seen[g+1] = seen[g] | elig[g];
    end

    assign valid = seen[N_LINES];

    always_comb begin
        idx = '0;
        for (int i = 0; i < int'(N_LINES); i++) begin
            if (win[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned N_LINES = 16,
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned GROUP   = 8,
    parameter int unsigned LO_BASE = 32,
    parameter int unsigned HI_BASE = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [N_LINES-1:0] cfg_wdata,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o
);

    localparam int unsigned IDX_W = $clog2(N_LINES);
    localparam int unsigned THR_W = $clog2(N_LINES + 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] line;
        logic [VEC_W-1:0] vec;
    } pres_t;

    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] mode_q;
    logic [N_LINES-1:0] pol_q;
    logic [THR_W-1:0]   thr_q;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] clr;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    pres_t              pres_d, pres_q;

    irqc_cfg_regs #(
        .N_LINES(N_LINES),
        .THR_W  (THR_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .mask_q(mask_q),
        .mode_q(mode_q),
        .pol_q (pol_q),
        .thr_q (thr_q)
    );

    irqc_capture #(
        .N_LINES(N_LINES)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(irq_in),
        .mask   (mask_q),
        .mode   (mode_q),
        .pol    (pol_q),
        .clr    (clr),
        .pend_o (pend)
    );

    irqc_prio_enc #(
        .N_LINES(N_LINES),
        .IDX_W  (IDX_W),
        .THR_W  (THR_W)
    ) u_enc (
        .req  (pend & ~mask_q),
        .thr  (thr_q),
        .valid(win_valid),
        .idx  (win_idx)
    );

    always_comb begin
        pres_d = pres_q;
        clr    = '0;
        if (pres_q.busy) begin
            if (ack_i) begin
                pres_d.busy       = 1'b0;
                clr[pres_q.line]  = 1'b1;
            end
        end else if (win_valid) begin
            pres_d.busy = 1'b1;
            pres_d.line = win_idx;
            pres_d.vec  = VEC_W'(line_vector(int'(win_idx), GROUP, LO_BASE, HI_BASE));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pres_q <= '0;
        end else begin
            pres_q <= pres_d;
        end
    end

    assign irq_o = pres_q.busy;
    assign vec_o = pres_q.vec;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned N_LINES = 16,
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned GROUP   = 8,
    parameter int unsigned LO_BASE = 32,
    parameter int unsigned HI_BASE = 40
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             irq_o,
    input  logic                             ack_i,
    input  logic [VEC_W-1:0]                 vec_o,
    input  logic [N_LINES-1:0]               mask_q,
    input  logic [$clog2(N_LINES + 1)-1:0]   thr_q
);

    localparam int unsigned IDX_W = $clog2(N_LINES);
    localparam int unsigned THR_W = $clog2(N_LINES + 1);

    logic [IDX_W-1:0]   line_w;
    logic               in_range;
    logic [N_LINES-1:0] mask_prev;
    logic [THR_W-1:0]   thr_prev;

    always_comb begin
        if (int'(vec_o) >= int'(HI_BASE)) begin
            line_w = IDX_W'(int'(vec_o) - int'(HI_BASE) + int'(GROUP));
        end else begin
            line_w = IDX_W'(int'(vec_o) - int'(LO_BASE));
        end
        in_range = ((int'(vec_o) >= int'(LO_BASE)) && (int'(vec_o) < int'(LO_BASE + GROUP))) ||
                   ((int'(vec_o) >= int'(HI_BASE)) && (int'(vec_o) < int'(HI_BASE + N_LINES - GROUP)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_prev <= '1;
            thr_prev  <= THR_W'(N_LINES);
        end else begin
            mask_prev <= mask_q;
            thr_prev  <= thr_q;
        end
    end

    p_hold_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

    p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> in_range);

    p_thr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (thr_prev > THR_W'(line_w)));

    p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !mask_prev[line_w]);

endmodule

bind irqc_top irqc_checker #(
    .N_LINES(N_LINES),
    .VEC_W  (VEC_W),
    .GROUP  (GROUP),
    .LO_BASE(LO_BASE),
    .HI_BASE(HI_BASE)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .irq_o (irq_o),
    .ack_i (ack_i),
    .vec_o (vec_o),
    .mask_q(mask_q),
    .thr_q (thr_q)
);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        ack_i = 1'b0;
    logic        irq_o;
    logic [7:0]  vec_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irqc_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .ack_i    (ack_i),
        .irq_o    (irq_o),
        .vec_o    (vec_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic int exp_vec(input int line);
        if (line < 8) return 32 + line;
        return 40 + (line - 8);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    initial begin
        logic [7:0] held;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 irq after reset", irq_o, 0);
        chk("R1 vec after reset", vec_o, 0);
        irq_in[3] = 1'b1;
        tick(4);
        chk("R1 lines masked after reset", irq_o, 0);

        // R10 mask register write: unmask all
        cfg_write(2'd0, 16'h0000);
        tick(3);
        chk("R10 no edge from line held during unmask", irq_o, 0);
        irq_in[3] = 1'b0;
        tick(2);

        // R3 R5 R11 edge sweep with merged second edge
        for (int i = 0; i < 16; i++) begin
            irq_in[i] = 1'b1;
            tick(1);
            chk("R11 not yet presented", irq_o, 0);
            tick(1);
            chk("R3 edge presented", irq_o, 1);
            chk("R5 vector", vec_o, exp_vec(i));
            irq_in[i] = 1'b0;
            tick(1);
            irq_in[i] = 1'b1;
            tick(1);
            chk("R9 vector held", vec_o, exp_vec(i));
            do_ack();
            chk("R9 released after ack", irq_o, 0);
            tick(3);
            chk("R3 merged edges give one request", irq_o, 0);
            irq_in[i] = 1'b0;
            tick(1);
        end

        // R4 level sweep
        cfg_write(2'd1, 16'hFFFF);
        for (int i = 0; i < 16; i++) begin
            irq_in[i] = 1'b1;
            tick(2);
            chk("R4 level presented", irq_o, 1);
            chk("R4 level vector", vec_o, exp_vec(i));
            do_ack();
            chk("R4 released", irq_o, 0);
            tick(1);
            chk("R4 re-request while held", irq_o, 1);
            chk("R4 re-request vector", vec_o, exp_vec(i));
            irq_in[i] = 1'b0;
            tick(1);
            do_ack();
            tick(2);
            chk("R4 no request after release", irq_o, 0);
        end

        // R6 threshold sweep in level mode
        for (int t = 0; t <= 16; t++) begin
            cfg_write(2'd3, 16'(t));
            for (int j = 0; j < 16; j++) begin
                irq_in = 16'hFFFF << j;
                tick(2);
                chk("R6 threshold gating", irq_o, (j < t) ? 1 : 0);
                if (j < t) chk("R6 highest passing line", vec_o, exp_vec(j));
                irq_in = '0;
                if (irq_o) do_ack();
                tick(2);
            end
        end
        cfg_write(2'd3, 16'd16);

        // R2 priority over all pairs in edge mode
        cfg_write(2'd1, 16'h0000);
        tick(2);
        for (int i = 0; i < 16; i++) begin
            for (int j = i + 1; j < 16; j++) begin
                irq_in[i] = 1'b1;
                irq_in[j] = 1'b1;
                tick(2);
                chk("R2 lower index first", vec_o, exp_vec(i));
                irq_in = '0;
                do_ack();
                tick(1);
                chk("R2 second presented", irq_o, 1);
                chk("R2 second vector", vec_o, exp_vec(j));
                do_ack();
                tick(1);
                chk("R2 pair drained", irq_o, 0);
            end
        end

        // R2 all lines at once drain in order
        irq_in = 16'hFFFF;
        tick(2);
        irq_in = '0;
        for (int k = 0; k < 16; k++) begin
            chk("R2 drain order", vec_o, exp_vec(k));
            do_ack();
            tick(1);
        end
        chk("R2 all drained", irq_o, 0);

        // R6 blocked edge stays pending
        cfg_write(2'd3, 16'd4);
        irq_in[9] = 1'b1;
        tick(1);
        irq_in[9] = 1'b0;
        tick(3);
        chk("R6 blocked line held back", irq_o, 0);
        cfg_write(2'd3, 16'd16);
        tick(1);
        chk("R6 pending presented after raise", irq_o, 1);
        chk("R6 pending vector", vec_o, exp_vec(9));
        do_ack();
        tick(2);

        // R7 active-low edge
        cfg_write(2'd0, 16'hFFFF);
        irq_in[5] = 1'b1;
        tick(1);
        cfg_write(2'd2, 16'h0020);
        cfg_write(2'd0, 16'h0000);
        tick(3);
        chk("R7 high is inactive when active-low", irq_o, 0);
        irq_in[5] = 1'b0;
        tick(2);
        chk("R7 falling edge captured", irq_o, 1);
        chk("R7 vector", vec_o, exp_vec(5));
        do_ack();
        tick(2);
        chk("R7 single edge request", irq_o, 0);

        // R7 active-low level
        cfg_write(2'd1, 16'h0020);
        tick(2);
        chk("R7 low level requests", irq_o, 1);
        do_ack();
        tick(1);
        chk("R7 low level re-requests", irq_o, 1);
        irq_in[5] = 1'b1;
        tick(1);
        do_ack();
        tick(2);
        chk("R7 high level idle", irq_o, 0);
        cfg_write(2'd0, 16'hFFFF);
        cfg_write(2'd2, 16'h0000);
        irq_in[5] = 1'b0;
        cfg_write(2'd1, 16'h0000);
        tick(1);
        cfg_write(2'd0, 16'h0000);
        tick(2);
        chk("R10 restored config idle", irq_o, 0);

        // R8 mask
        cfg_write(2'd0, 16'h0040);
        irq_in[6] = 1'b1;
        tick(1);
        irq_in[6] = 1'b0;
        tick(3);
        chk("R8 masked line not presented", irq_o, 0);
        cfg_write(2'd0, 16'h0000);
        tick(3);
        chk("R8 masked edge not captured", irq_o, 0);
        irq_in[6] = 1'b1;
        tick(2);
        chk("R8 unmasked edge presented", vec_o, exp_vec(6));
        irq_in[6] = 1'b0;
        do_ack();
        tick(2);

        // R9 ack while idle is ignored
        held = vec_o;
        do_ack();
        do_ack();
        chk("R9 idle ack irq", irq_o, 0);
        chk("R9 idle ack vec", vec_o, held);
        irq_in[2] = 1'b1;
        tick(2);
        chk("R9 presentation after idle ack", vec_o, exp_vec(2));
        tick(3);
        chk("R9 held without ack", irq_o, 1);
        chk("R9 vec held without ack", vec_o, exp_vec(2));
        irq_in[2] = 1'b0;
        do_ack();
        tick(2);
        chk("R9 idle at end", irq_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule